// File: doc/BRIEF.md
# Bit-Reversed Strided Load Address Unit

This unit serves vector-element loads whose elements are visited in bit-reversed index order, the access pattern of radix-2 FFT butterflies. For each element it takes the element index, the log2 of the vector length, a signed immediate stride, a shift operand and a base value. It forms the effective address as the base plus the bit-reversed index times the stride, shifted left. It sends the address to memory, waits for the reply and formats the returned data into a 64-bit result. The formatting is zero- or sign-extension, depending on the access kind.

When the update flag is set, the unit also presents the computed address with a write-back strobe so that the base register can be replaced. Instruction decode, the register file and fault handling stay outside.

Top module: `brev_load_agu`

## Requirements
- R1: The address equals base + ((rev × simm) << n), with every step kept to the low 64 bits, so sums and products wrap modulo 2^64.
- R2: The shift amount n is `shamt[5:0]`. Bits 63:6 of `shamt` have no effect on the address.
- R3: rev is the low `vl_log2` bits of `step` in reversed order, and zero above them. Bit j of step moves to bit `vl_log2`-1-j. Step bits at or above `vl_log2` are ignored. With `vl_log2` = 0, rev is 0 and the address equals the base. Valid values of `vl_log2` are 0 to 6.
- R4: Without update, `base_zero` = 1 replaces the base with 0.
- R5: With update, the base is always `base_val`, whatever `base_zero` is. `wb_valid` is high in the same cycle as `res_valid`, with `wb_addr` equal to the address. Without update, `wb_valid` stays low.
- R6: Kind codes 0 (byte), 1 (halfword) and 3 (word) return the low 8, 16 or 32 bits of `mem_rdata`, with all higher bits zero.
- R7: Kind codes 2 (halfword) and 4 (word) return the low 16 or 32 bits of `mem_rdata`, sign-extended to 64 bits.
- R8: Kind code 5 (doubleword) returns `mem_rdata` unchanged.
- R9: For kinds 4 and 5 the stride is `{imm[IMM_W-3:0],2'b00}`, sign-extended, and the top two immediate bits are ignored. For the other kinds the stride is `imm`, sign-extended.
- R10: `mem_req` rises in the cycle after an accepted `start`. It stays high until the first edge at which `mem_ack` is sampled high. While it is high, `mem_addr` and `mem_size` do not change. `mem_size` holds the byte count: 1 for kind 0, 2 for kinds 1 and 2, 4 for kinds 3 and 4, and 8 for kind 5.
- R11: `res_valid` is a one-cycle pulse in the cycle after the edge that samples `mem_ack`. A `start` seen while `mem_req` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one element access |
| kind | input | 3 | Access kind code |
| update | input | 1 | Update form: write address back |
| base_zero | input | 1 | Base selector is zero |
| base_val | input | 64 | Base register value |
| imm | input | IMM_W | Signed stride immediate |
| shamt | input | 64 | Shift operand (low 6 bits used) |
| step | input | 6 | Element index |
| vl_log2 | input | 3 | log2 of vector length |
| mem_req | output | 1 | Memory request |
| mem_addr | output | 64 | Request address |
| mem_size | output | 4 | Request size in bytes |
| mem_ack | input | 1 | Memory reply strobe |
| mem_rdata | input | 64 | Memory reply data, low aligned |
| res_valid | output | 1 | Result strobe |
| res_data | output | 64 | Formatted result |
| wb_valid | output | 1 | Base write-back strobe |
| wb_addr | output | 64 | Address to write back |

## Verification
The request and its address are due one cycle after the edge that accepts `start`. The result and the write-back strobe are due one cycle after the edge that samples `mem_ack`, and `res_valid` must be low again one cycle after that. The bench drives every input at a falling edge and samples at the next falling edge, so each check lands exactly one register stage after its cause. While it waits for the acknowledge, it checks on each cycle that the address stays fixed and that `res_valid` stays low.

// File: rtl/brev_load_agu.sv
module brev_load_agu #(
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       kind,
  input  logic             update,
  input  logic             base_zero,
  input  logic [63:0]      base_val,
  input  logic [IMM_W-1:0] imm,
  input  logic [63:0]      shamt,
  input  logic [5:0]       step,
  input  logic [2:0]       vl_log2,
  output logic             mem_req,
  output logic [63:0]      mem_addr,
  output logic [3:0]       mem_size,
  input  logic             mem_ack,
  input  logic [63:0]      mem_rdata,
  output logic             res_valid,
  output logic [63:0]      res_data,
  output logic             wb_valid,
  output logic [63:0]      wb_addr
);
  localparam int MAX_LG = 6;
  localparam logic [2:0] K_BZ = 3'd0, K_HZ = 3'd1, K_HA = 3'd2,
                         K_WZ = 3'd3, K_WA = 3'd4;

  logic [2:0]  lg;
  logic [5:0]  rev;
  logic [63:0] stride, base_eff, offset, ea;
  logic [2:0]  kind_q;
  logic        upd_q;
  logic [63:0] fmt;

  assign lg = (vl_log2 > 3'(MAX_LG)) ? 3'(MAX_LG) : vl_log2;

  always_comb begin
    for (int i = 0; i < MAX_LG; i++) begin
      rev[i] = 1'b0;
      for (int j = 0; j < MAX_LG; j++)
        if (j == int'(lg) - 1 - i) rev[i] = step[j];
    end
  end

  assign stride = (kind == K_WA || kind >= 3'd5)
                ? {{(66-IMM_W){imm[IMM_W-3]}}, imm[IMM_W-3:0], 2'b00}
                : {{(64-IMM_W){imm[IMM_W-1]}}, imm};
  assign base_eff = (!update && base_zero) ? 64'd0 : base_val;
  assign offset = (stride * {58'd0, rev}) << shamt[5:0];
  assign ea = base_eff + offset;

  always_comb begin
    case (kind_q)
      K_BZ:    fmt = {56'd0, mem_rdata[7:0]};
      K_HZ:    fmt = {48'd0, mem_rdata[15:0]};
      K_HA:    fmt = {{48{mem_rdata[15]}}, mem_rdata[15:0]};
      K_WZ:    fmt = {32'd0, mem_rdata[31:0]};
      K_WA:    fmt = {{32{mem_rdata[31]}}, mem_rdata[31:0]};
      default: fmt = mem_rdata;
    endcase
  end

  always_comb begin
    case (kind_q)
      K_BZ:       mem_size = 4'd1;
      K_HZ, K_HA: mem_size = 4'd2;
      K_WZ, K_WA: mem_size = 4'd4;
      default:    mem_size = 4'd8;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      kind_q    <= '0;
      upd_q     <= 1'b0;
      res_valid <= 1'b0;
      wb_valid  <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      wb_valid  <= 1'b0;
      if (!mem_req && start) begin
        mem_req  <= 1'b1;
        mem_addr <= ea;
        kind_q   <= kind;
        upd_q    <= update;
      end else if (mem_req && mem_ack) begin
        mem_req   <= 1'b0;
        res_valid <= 1'b1;
        wb_valid  <= upd_q;
        res_data  <= fmt;
      end
    end
  end

  assign wb_addr = mem_addr;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_size));
  // R10
  size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $countones(mem_size) == 1);
  // R11
  res_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> res_valid && !mem_req);
  // R11
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R11
  res_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(mem_req) && $past(mem_ack));
  // R5
  wb_with_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> res_valid);
endmodule

// File: tb/brev_load_agu_bench.sv
`timescale 1ns/1ps
module brev_load_agu_bench;
  logic clk = 0, rst_n = 0, start = 0, update = 0, base_zero = 0, mem_ack = 0;
  logic [2:0] kind = 0, vl_log2 = 0;
  logic [63:0] base_val = 0, shamt = 0, mem_rdata = 0;
  logic [15:0] imm = 0;
  logic [5:0] step = 0;
  logic mem_req, res_valid, wb_valid;
  logic [63:0] mem_addr, res_data, wb_addr;
  logic [3:0] mem_size;
  int total = 0, bad = 0;
  bit res_expect = 0;

  always #2.5 clk = ~clk;

  brev_load_agu #(.IMM_W(16)) u_brev_load_agu (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .update(update),
    .base_zero(base_zero), .base_val(base_val), .imm(imm), .shamt(shamt),
    .step(step), .vl_log2(vl_log2), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_data(res_data), .wb_valid(wb_valid),
    .wb_addr(wb_addr));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    total++;
    if (res_valid !== res_expect) begin
      bad++;
      $display("FAIL R11 res_valid actual=%b expected=%b", res_valid, res_expect);
    end
  end

  function automatic logic [63:0] model_ea(int k, bit upd, bit rz, logic [63:0] b,
      logic [15:0] im, logic [63:0] sh, logic [5:0] st, int lg);
    longint s, r, off;
    if (k == 4 || k == 5) s = longint'($signed({im[13:0], 2'b00}));
    else s = longint'($signed(im));
    r = 0;
    for (int q = 0; q < lg; q++) if (st[q]) r = r | (64'd1 << (lg - 1 - q));
    off = (r * s) << sh[5:0];
    return ((!upd && rz) ? 64'd0 : b) + off;
  endfunction

  function automatic logic [63:0] model_fmt(int k, logic [63:0] d);
    case (k)
      0: return {56'd0, d[7:0]};
      1: return {48'd0, d[15:0]};
      2: return {{48{d[15]}}, d[15:0]};
      3: return {32'd0, d[31:0]};
      4: return {{32{d[31]}}, d[31:0]};
      default: return d;
    endcase
  endfunction

  task automatic run(string tag, int k, bit upd, bit rz, logic [63:0] b,
      logic [15:0] im, logic [63:0] sh, logic [5:0] st, int lg,
      logic [63:0] rd, int wait_n, bit poke);
    logic [63:0] ea;
    logic [3:0] sz;
    ea = model_ea(k, upd, rz, b, im, sh, st, lg);
    sz = (k == 0) ? 4'd1 : (k <= 2) ? 4'd2 : (k <= 4) ? 4'd4 : 4'd8;
    kind = 3'(k); update = upd; base_zero = rz; base_val = b; imm = im;
    shamt = sh; step = st; vl_log2 = 3'(lg); start = 1;
    @(negedge clk);
    start = 0;
    chk({tag, " R10 req"}, 64'(mem_req), 64'd1);
    chk({tag, " R1 addr"}, mem_addr, ea);
    chk({tag, " R10 size"}, 64'(mem_size), 64'(sz));
    for (int w = 0; w < wait_n; w++) begin
      if (poke) begin start = 1; base_val = ~b; kind = 3'd5; end
      @(negedge clk);
      start = 0;
      chk({tag, " R10 hold req"}, 64'(mem_req), 64'd1);
      chk({tag, " R11 busy start ignored addr"}, mem_addr, ea);
      chk({tag, " R10 hold size"}, 64'(mem_size), 64'(sz));
    end
    mem_ack = 1; mem_rdata = rd; res_expect = 0;
    @(posedge clk);
    res_expect = 1;
    @(negedge clk);
    mem_ack = 0; mem_rdata = 64'h0;
    chk({tag, " R6/R7/R8 data"}, res_data, model_fmt(k, rd));
    chk({tag, " R5 wb_valid"}, 64'(wb_valid), 64'(upd));
    if (upd) chk({tag, " R5 wb_addr"}, wb_addr, ea);
    chk({tag, " R10 req dropped"}, 64'(mem_req), 64'd0);
    @(posedge clk);
    res_expect = 0;
    @(negedge clk);
    chk({tag, " R11 pulse end"}, 64'(res_valid), 64'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset R10 req", 64'(mem_req), 64'd0);
    chk("reset R11 res", 64'(res_valid), 64'd0);
    chk("reset R5 wb", 64'(wb_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    // R1 R3 R6 byte zero
    run("t1", 0, 0, 0, 64'h1000, 16'd3, 64'd0, 6'd1, 3, 64'hFFFF_FFFF_FFFF_FF80, 0, 0);
    // R6 halfword zero, negative stride, shift 1
    run("t2", 1, 0, 0, 64'h2000, 16'hFFFE, 64'd1, 6'd3, 3, 64'h1234_5678_9ABC_8001, 2, 0);
    // R7 halfword algebraic
    run("t3", 2, 0, 0, 64'h2000, 16'h0005, 64'd2, 6'd5, 4, 64'h1234_5678_9ABC_8001, 1, 0);
    // R6 word zero
    run("t4", 3, 0, 0, 64'h40, 16'h0010, 64'd0, 6'd2, 2, 64'hDEAD_BEEF_8765_4321, 0, 0);
    // R7 R9 word algebraic, top immediate bits ignored
    run("t5", 4, 0, 0, 64'h8000, 16'hC001, 64'd0, 6'd1, 1, 64'hDEAD_BEEF_8765_4321, 0, 0);
    // R8 R9 doubleword, stride {0x3FFF,00} = -4
    run("t6", 5, 0, 0, 64'h8000, 16'h3FFF, 64'd1, 6'd6, 6, 64'hDEAD_BEEF_8765_4321, 0, 0);
    // R4 zero base selector without update
    run("t7", 3, 0, 1, 64'h5555_0000, 16'd8, 64'd0, 6'd1, 2, 64'h0000_0000_7FFF_FFFF, 0, 0);
    // R5 update ignores zero selector
    run("t8", 5, 1, 1, 64'h5555_0000, 16'd8, 64'd0, 6'd1, 2, 64'h0102_0304_0506_0708, 1, 0);
    // R2 upper shift bits ignored
    run("t9", 0, 1, 0, 64'h100, 16'd1, 64'hFFFF_FFFF_FFFF_FFC3, 6'd1, 2, 64'h7F, 0, 0);
    // R3 vl_log2 = 0 gives base only; upper step bits ignored
    run("t10", 1, 0, 0, 64'h300, 16'h7FFF, 64'd4, 6'h3F, 0, 64'h0000_0000_0000_7FFF, 0, 0);
    run("t11", 1, 0, 0, 64'h300, 16'd1, 64'd0, 6'b111010, 2, 64'h0, 0, 0);
    // R1 wraparound of product, shift and sum
    run("t12", 5, 1, 0, 64'hFFFF_FFFF_FFFF_FFF0, 16'h7FFF, 64'd50, 6'd63, 6, 64'hFFFF_0000_FFFF_0000, 0, 0);
    // R11 start during pending request is ignored
    run("t13", 2, 0, 0, 64'hA000, 16'd2, 64'd0, 6'd3, 2, 64'h0000_0000_0000_7001, 3, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule